// File: doc/BRIEF.md
# Transmit Gating and Collision Reporting for a 10/100 PHY

This block sits between the transmit side of a media access controller and the line encoder of a 10/100 physical-layer transceiver. Each clock it takes the enable, error flag and data nibble from the controller and presents a registered, gated copy to the encoder. A management-controlled disable bit blocks transmission. The bit is honoured only where a packet starts, so the line never carries a truncated frame. At 100 Mb/s an errored nibble is swapped for a HALT marker. At 10 Mb/s the error flag leaves the data untouched.

The block also drives the collision output. In half duplex the output rises whenever a nibble actually goes to the line while the receiver reports activity. In full duplex it stays low. A collision-test mode echoes the transmit enable onto the collision output with bounded latencies. Those latencies are measured in bit times, using a per-bit enable pulse whose spacing follows the selected speed.

Top module: `tx_gate_col`

## Requirements
- R1: While reset is held and on the first cycle after it, outValid, outHalt, outNibble and col are all 0.
- R2: When transmission is allowed, outValid, outNibble follow txEn and txData one clock later.
- R3: Setting txDisable while a packet is passing does not cut that packet: every nibble up to the fall of txEn still reaches the output.
- R4: A packet whose txEn rises while txDisable is 1 never produces outValid, and neither does any later packet until txDisable is 0 at a rising txEn.
- R5: Clearing txDisable while txEn is high on a blocked packet keeps outValid at 0 until txEn falls; the next packet then passes.
- R6: With speed100=1, a passing nibble with txEr=1 appears one clock later as outValid=1, outHalt=1, outNibble=4'b0000.
- R7: With speed100=0, txEr has no effect: outHalt stays 0 and outNibble equals txData.
- R8: With fullDuplex=0 and colTest=0, col one clock later equals (a nibble passed) AND rxActive.
- R9: With fullDuplex=1 and colTest=0, col is 0 one clock later, whatever txEn and rxActive do.
- R10: With colTest=1, col rises within 10 bit times after txEn rises, is still 0 on the first clock after the rise, and stays 1 while txEn is high.
- R11: With colTest=1, col falls within 4 bit times after txEn falls.
- R12: If txEn is already high when reset is released, that packet is treated as a fragment and blocked until txEn falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable from the controller |
| txEr | input | 1 | Transmit error flag from the controller |
| txData | input | NIB_W | Transmit nibble from the controller |
| rxActive | input | 1 | Receiver reports carrier activity |
| fullDuplex | input | 1 | 1 selects full duplex |
| speed100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| txDisable | input | 1 | Management transmit disable bit |
| colTest | input | 1 | Management collision-test bit |
| outValid | output | 1 | Gated enable to the encoder |
| outHalt | output | 1 | Nibble replaced by HALT |
| outNibble | output | NIB_W | Gated nibble to the encoder |
| col | output | 1 | Collision indication |

## Verification
The hardest case to reach is a packet already in flight when the gating decision is made. Two instances of it are a packet caught mid-flight by reset and a disable bit that changes between the rise and the fall of txEn. The bench reaches the first by holding txEn high across the release of reset. It reaches the second by toggling txDisable on a clock inside the packet, and it confirms both the blocked and the passing cases through outValid. The collision-test latencies are sampled at the early edge and at the late bound in 10 Mb/s mode. There the bit pulses are far apart, so an off-by-one in tick counting shows up as a window miss.

// File: rtl/txgc_pkg.sv
`timescale 1ns/1ps
package txgc_pkg;
  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic gateOpen;  // nibble goes to the line this cycle
    logic haltNib;   // replace the nibble with HALT
  } txgc_strobe_t;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_ARM  = 2'd1,
    CT_ON   = 2'd2,
    CT_REL  = 2'd3
  } colt_state_e;
endpackage

// File: rtl/txgc_bit_timer.sv
`timescale 1ns/1ps
module txgc_bit_timer #(
  parameter int CLKS_PER_BIT_FAST = 2,
  parameter int CLKS_PER_BIT_SLOW = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic speed100,
  output logic bitTick
);
  localparam int MAX_CPB = (CLKS_PER_BIT_SLOW > CLKS_PER_BIT_FAST) ?
                           CLKS_PER_BIT_SLOW : CLKS_PER_BIT_FAST;
  localparam int CNT_W = $clog2(MAX_CPB + 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(CLKS_PER_BIT_FAST - 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(CLKS_PER_BIT_SLOW - 1);

  logic [CNT_W-1:0] cnt;
  logic             speedQ;
  logic [CNT_W-1:0] lim;

  assign lim     = speed100 ? FAST_LIM : SLOW_LIM;
  assign bitTick = (cnt == lim) && (speedQ == speed100);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      speedQ <= 1'b0;
    end else begin
      speedQ <= speed100;
      if (speedQ != speed100 || cnt == lim) cnt <= '0;
      else                                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txgc_ctrl.sv
`timescale 1ns/1ps
module txgc_ctrl
  import txgc_pkg::*;
#(
  parameter int TEST_ON_BITS  = 8,
  parameter int TEST_OFF_BITS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txEn,
  input  logic         txEr,
  input  logic         txDisable,
  input  logic         speed100,
  input  logic         fullDuplex,
  input  logic         rxActive,
  input  logic         colTest,
  input  logic         bitTick,
  output txgc_strobe_t strobe,
  output logic         col
);
  localparam int MAX_BITS = (TEST_ON_BITS > TEST_OFF_BITS) ? TEST_ON_BITS : TEST_OFF_BITS;
  localparam int TC_W = $clog2(MAX_BITS + 1);
  localparam logic [TC_W-1:0] ON_LAST  = TC_W'(TEST_ON_BITS - 1);
  localparam logic [TC_W-1:0] OFF_LAST = TC_W'(TEST_OFF_BITS - 1);

  logic        txEnQ;     // previous txEn, held high in reset
  logic        passQ;     // current packet is allowed
  logic        pktRise;
  logic        gateOpen;
  logic        colRealQ;
  colt_state_e ctState, ctNext;
  logic [TC_W-1:0] tCnt, tCntNext;

  // Packet-boundary gating
  assign pktRise  = txEn && !txEnQ;
  assign gateOpen = txEn && (pktRise ? !txDisable : passQ);

  assign strobe.gateOpen = gateOpen;
  assign strobe.haltNib  = gateOpen && speed100 && txEr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnQ    <= 1'b1;
      passQ    <= 1'b0;
      colRealQ <= 1'b0;
    end else begin
      txEnQ    <= txEn;
      passQ    <= gateOpen;
      colRealQ <= !fullDuplex && gateOpen && rxActive;
    end
  end

  // Collision-test echo with tick-counted latencies
  always_comb begin
    ctNext   = ctState;
    tCntNext = tCnt;
    if (!colTest) begin
      ctNext   = CT_IDLE;
      tCntNext = '0;
    end else begin
      unique case (ctState)
        CT_IDLE: if (txEn) begin
          ctNext   = CT_ARM;
          tCntNext = '0;
        end
        CT_ARM: begin
          if (!txEn) begin
            ctNext = CT_IDLE;
          end else if (bitTick) begin
            if (tCnt == ON_LAST) ctNext = CT_ON;
            else                 tCntNext = tCnt + 1'b1;
          end
        end
        CT_ON: if (!txEn) begin
          ctNext   = CT_REL;
          tCntNext = '0;
        end
        CT_REL: begin
          if (txEn) begin
            ctNext = CT_ON;
          end else if (bitTick) begin
            if (tCnt == OFF_LAST) ctNext = CT_IDLE;
            else                  tCntNext = tCnt + 1'b1;
          end
        end
        default: ctNext = CT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctState <= CT_IDLE;
      tCnt    <= '0;
    end else begin
      ctState <= ctNext;
      tCnt    <= tCntNext;
    end
  end

  assign col = colRealQ || (ctState == CT_ON) || (ctState == CT_REL);
endmodule

// File: rtl/txgc_data.sv
`timescale 1ns/1ps
module txgc_data
  import txgc_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  txgc_strobe_t     strobe,
  input  logic [NIB_W-1:0] txData,
  output logic             outValid,
  output logic             outHalt,
  output logic [NIB_W-1:0] outNibble
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outHalt   <= 1'b0;
      outNibble <= '0;
    end else begin
      outValid  <= strobe.gateOpen;
      outHalt   <= strobe.haltNib;
      outNibble <= (strobe.gateOpen && !strobe.haltNib) ? txData : '0;
    end
  end
endmodule

// File: rtl/tx_gate_col.sv
`timescale 1ns/1ps
module tx_gate_col
  import txgc_pkg::*;
#(
  parameter int NIB_W             = 4,
  parameter int CLKS_PER_BIT_FAST = 2,
  parameter int CLKS_PER_BIT_SLOW = 20,
  parameter int TEST_ON_BITS      = 8,
  parameter int TEST_OFF_BITS     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             txEr,
  input  logic [NIB_W-1:0] txData,
  input  logic             rxActive,
  input  logic             fullDuplex,
  input  logic             speed100,
  input  logic             txDisable,
  input  logic             colTest,
  output logic             outValid,
  output logic             outHalt,
  output logic [NIB_W-1:0] outNibble,
  output logic             col
);
  logic         bitTick;
  txgc_strobe_t strobe;

  txgc_bit_timer #(
    .CLKS_PER_BIT_FAST(CLKS_PER_BIT_FAST),
    .CLKS_PER_BIT_SLOW(CLKS_PER_BIT_SLOW)
  ) u_timer (
    .clk(clk), .rstN(rstN), .speed100(speed100), .bitTick(bitTick)
  );

  txgc_ctrl #(
    .TEST_ON_BITS(TEST_ON_BITS),
    .TEST_OFF_BITS(TEST_OFF_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txDisable(txDisable),
    .speed100(speed100), .fullDuplex(fullDuplex), .rxActive(rxActive),
    .colTest(colTest), .bitTick(bitTick), .strobe(strobe), .col(col)
  );

  txgc_data #(.NIB_W(NIB_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .outValid(outValid), .outHalt(outHalt), .outNibble(outNibble)
  );
endmodule

// File: rtl/txgc_checker.sv
`timescale 1ns/1ps
module txgc_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             txEn,
  input logic [NIB_W-1:0] txData,
  input logic             rxActive,
  input logic             fullDuplex,
  input logic             speed100,
  input logic             txDisable,
  input logic             colTest,
  input logic             outValid,
  input logic             outHalt,
  input logic [NIB_W-1:0] outNibble,
  input logic             col
);
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> !outValid); // R2

  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHalt && rstN && $past(rstN)) |-> (outNibble == $past(txData))); // R2

  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txEn) && txDisable) |=> !outValid); // R4

  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outHalt |-> (outValid && outNibble == '0)); // R6

  AST_SLOW_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    !speed100 |=> !outHalt); // R7

  AST_HALF_COL: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && !colTest) |=> (col == (outValid && $past(rxActive)))); // R8

  AST_FULL_NO_COL: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex && !colTest) |=> !col); // R9

  AST_TEST_NO_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (colTest && $rose(txEn) && !col) |=> !col); // R10
endmodule

bind tx_gate_col txgc_checker #(.NIB_W(NIB_W)) u_txgc_checker (
  .clk(clk), .rstN(rstN), .txEn(txEn), .txData(txData), .rxActive(rxActive),
  .fullDuplex(fullDuplex), .speed100(speed100), .txDisable(txDisable),
  .colTest(colTest), .outValid(outValid), .outHalt(outHalt),
  .outNibble(outNibble), .col(col)
);

// File: tb/tx_gate_col_bench.sv
`timescale 1ns/1ps
module tx_gate_col_bench;
  localparam int NIB_W = 4;
  localparam int CPB_FAST = 2;
  localparam int CPB_SLOW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0, txEr = 1'b0, rxActive = 1'b0, fullDuplex = 1'b0;
  logic speed100 = 1'b1, txDisable = 1'b0, colTest = 1'b0;
  logic [NIB_W-1:0] txData = '0;
  logic outValid, outHalt, col;
  logic [NIB_W-1:0] outNibble;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tx_gate_col #(.NIB_W(NIB_W), .CLKS_PER_BIT_FAST(CPB_FAST),
                .CLKS_PER_BIT_SLOW(CPB_SLOW)) u_tx_gate_col (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txData(txData),
    .rxActive(rxActive), .fullDuplex(fullDuplex), .speed100(speed100),
    .txDisable(txDisable), .colTest(colTest), .outValid(outValid),
    .outHalt(outHalt), .outNibble(outNibble), .col(col)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    txEn = 0; txEr = 0; rxActive = 0; txDisable = 0; colTest = 0;
    fullDuplex = 0; speed100 = 1; txData = '0;
    step(2);
  endtask

  task automatic t_reset();
    rstN = 0; step(3);
    chk("R1 valid in reset", outValid, 0);
    chk("R1 col in reset", col, 0);
    rstN = 1; step(1);
    chk("R1 valid after reset", outValid, 0);
    chk("R1 nibble after reset", {outHalt, outNibble}, 0);
    chk("R1 col after reset", col, 0);
  endtask

  task automatic t_pass();
    txEn = 1; txData = 4'hA; step(1);
    chk("R2 valid", outValid, 1); chk("R2 nibble A", outNibble, 4'hA);
    txData = 4'h5; step(1);
    chk("R2 nibble 5", outNibble, 4'h5);
    txEn = 0; step(1);
    chk("R2 valid drop", outValid, 0);
    quiet();
  endtask

  task automatic t_disable_mid();
    txEn = 1; txData = 4'h3; step(1);
    chk("R3 first nibble valid", outValid, 1);
    txDisable = 1; txData = 4'hC; step(1);
    chk("R3 packet continues", outValid, 1);
    chk("R3 nibble C", outNibble, 4'hC);
    step(1);
    chk("R3 still continues", outValid, 1);
    txEn = 0; step(1);
    txEn = 1; step(1);
    chk("R4 later packet blocked", outValid, 0);
    step(2);
    chk("R4 later packet stays blocked", outValid, 0);
    quiet();
  endtask

  task automatic t_clear_mid();
    txDisable = 1; txEn = 1; txData = 4'h7; step(1);
    chk("R4 blocked at start", outValid, 0);
    txDisable = 0; step(1);
    chk("R5 blocked after clear", outValid, 0);
    step(2);
    chk("R5 still blocked", outValid, 0);
    txEn = 0; step(1);
    txEn = 1; step(1);
    chk("R5 next packet passes", outValid, 1);
    chk("R5 nibble", outNibble, 4'h7);
    quiet();
  endtask

  task automatic t_halt100();
    speed100 = 1; txEn = 1; txData = 4'hF; step(1);
    txEr = 1; step(1);
    chk("R6 halt flag", outHalt, 1);
    chk("R6 halt nibble", outNibble, 0);
    chk("R6 halt valid", outValid, 1);
    txEr = 0; step(1);
    chk("R6 halt clears", {outHalt, outNibble}, 5'h0F);
    quiet();
  endtask

  task automatic t_er10();
    speed100 = 0; step(2);
    txEn = 1; txEr = 1; txData = 4'h9; step(1);
    chk("R7 no halt at 10M", outHalt, 0);
    chk("R7 data kept at 10M", outNibble, 4'h9);
    quiet();
  endtask

  task automatic t_half_col();
    fullDuplex = 0; rxActive = 1; txEn = 1; step(1);
    chk("R8 collision", col, 1);
    rxActive = 0; step(1);
    chk("R8 rx gone", col, 0);
    txEn = 0; rxActive = 1; step(1);
    chk("R8 rx only", col, 0);
    txDisable = 1; txEn = 1; step(1);
    chk("R8 blocked tx no col", col, 0);
    quiet();
  endtask

  task automatic t_full_col();
    fullDuplex = 1; rxActive = 1; txEn = 1; step(3);
    chk("R9 full duplex col", col, 0);
    quiet();
  endtask

  task automatic t_coltest(input bit fast);
    int cpb;
    cpb = fast ? CPB_FAST : CPB_SLOW;
    speed100 = fast; fullDuplex = 1; colTest = 1; step(2);
    txEn = 1; step(1);
    chk("R10 not early", col, 0);
    step(10 * cpb - 1);
    chk("R10 asserted in window", col, 1);
    step(5);
    chk("R10 held", col, 1);
    txEn = 0; step(1);
    chk("R11 not dropped at once", col, 1);
    step(4 * cpb - 1);
    chk("R11 released in window", col, 0);
    quiet();
  endtask

  task automatic t_reset_mid();
    rstN = 0; txEn = 1; txData = 4'h6; step(2);
    rstN = 1; step(1);
    chk("R12 fragment blocked", outValid, 0);
    step(3);
    chk("R12 fragment stays blocked", outValid, 0);
    txEn = 0; step(1);
    txEn = 1; step(1);
    chk("R12 next packet passes", outValid, 1);
    quiet();
  endtask

  initial begin
    step(1);
    t_reset();
    quiet();
    t_pass();
    t_disable_mid();
    t_clear_mid();
    t_halt100();
    t_er10();
    t_half_col();
    t_full_col();
    t_coltest(1'b1);
    t_coltest(1'b0);
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule